// File: doc/BRIEF.md
# Rotated Immediate Codec

This block converts between the 12-bit immediate field of a data-processing instruction and the 32-bit constant that the field stands for. The field packs an 8-bit payload and a 4-bit rotation count. The constant is the payload, zero-extended to 32 bits and rotated right by twice that count. Because the operation is a rotation, bits that leave the low end come back in at the top. No left shift is ever involved.

The decode side expands a field into its constant and also produces the shifter carry-out. The encode side takes an arbitrary 32-bit constant and searches all sixteen rotations for one that fits. It reports whether the constant can be represented at all. When several fields give the same constant, it returns the one with the smallest rotation count. Each side has its own input strobe. Results appear one clock later, together with an output strobe.

A pipeline uses the decode side when it fetches operands. An assembler or a code-generation unit uses the encode side to choose the field for a constant.

Top module: `rotimm_codec`

## Requirements
- R1: Field bits [7:0] hold the payload and bits [11:8] hold the rotation count. The decoded constant is the payload zero-extended to 32 bits and rotated right by twice the count (field 0x002 gives 0x00000002).
- R2: The decode rotation wraps: bits leaving bit 0 re-enter at bit 31. Field 0x808 gives 0x00080000 and field 0x1FF gives 0xC000003F.
- R3: Decoder carry-out equals `dec_carry_in` when the rotation count is 0. Otherwise it equals bit 31 of the decoded constant.
- R4: For a representable constant the encoder raises `enc_ok`, and its field decodes back to that same constant.
- R5: The encoder returns the field with the smallest rotation count that yields the constant. 0x00080000 encodes as 0x702, and 0x00000000 encodes as 0x000.
- R6: For a constant that no rotation from 0 to 15 can produce (0x00000101, 0xFFFFFFFF), the encoder clears `enc_ok` and outputs field 0x000.
- R7: Each side's results update, and its output strobe is high, exactly one cycle after its input strobe. Without an input strobe the output strobe is low and the results hold their last value.
- R8: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_in_valid | input | 1 | Decode request strobe |
| dec_field | input | 12 | Field to expand (rotation count in [11:8], payload in [7:0]) |
| dec_carry_in | input | 1 | Current carry flag, passed through when the rotation count is 0 |
| dec_out_valid | output | 1 | Decode result strobe |
| dec_value | output | 32 | Expanded constant |
| dec_carry_out | output | 1 | Shifter carry-out |
| enc_in_valid | input | 1 | Encode request strobe |
| enc_value | input | 32 | Constant to encode |
| enc_out_valid | output | 1 | Encode result strobe |
| enc_ok | output | 1 | Constant is representable |
| enc_field | output | 12 | Minimal-rotation field, 0 when not representable |

## Verification
A wrong rotation amount or direction in the expander shows up at `dec_value` in the cycle after the request. It corrupts every field with a nonzero count, and it also breaks the decode-then-encode round trip.

A fault in the priority pick of the search shows up at `enc_field` in the cycle after the request. The field it returns is a valid but non-minimal encoding, so the bench runs all 4096 fields through both sides to compare each result against a minimal field it computes by its own search.

A wrong carry source appears only on fields with a nonzero count whose constant has bit 31 set, or on count-0 fields with the carry input high. The directed vectors cover both cases.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned IMM_W  = 8;
  parameter int unsigned ROT_W  = 4;

  localparam int unsigned ROT_N    = 1 << ROT_W;
  localparam int unsigned ROT_STEP = WORD_W / ROT_N;
  localparam int unsigned FIELD_W  = IMM_W + ROT_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [ROT_W-1:0]   rot_t;
  typedef logic [IMM_W-1:0]   imm_t;

  // Rotate toward bit 0; bits leaving bit 0 re-enter at the top.
  function automatic word_t rot_right(word_t x, int unsigned amt);
    int unsigned a;
    a = amt % WORD_W;
    if (a == 0) return x;
    return (x >> a) | (x << (WORD_W - a));
  endfunction

  // Inverse of rot_right, used by the encoder search.
  function automatic word_t rot_left(word_t x, int unsigned amt);
    int unsigned a;
    a = amt % WORD_W;
    if (a == 0) return x;
    return (x << a) | (x >> (WORD_W - a));
  endfunction

  function automatic rot_t field_rot(field_t f);
    return f[FIELD_W-1:IMM_W];
  endfunction

  function automatic imm_t field_imm(field_t f);
    return f[IMM_W-1:0];
  endfunction

  // Constant denoted by a field.
  function automatic word_t field_to_word(field_t f);
    return rot_right(word_t'(field_imm(f)), int'(field_rot(f)) * ROT_STEP);
  endfunction
endpackage

// File: rtl/rotimm_expand.sv
module rotimm_expand
  import rotimm_pkg::*;
(
  input  field_t field_i,
  input  logic   carry_i,
  output word_t  value_o,
  output logic   carry_o,
  output logic   rot_zero_o
);
  word_t value_w;

  assign value_w    = field_to_word(field_i);
  assign rot_zero_o = (field_rot(field_i) == '0);
  assign value_o    = value_w;
  assign carry_o    = rot_zero_o ? carry_i : value_w[WORD_W-1];
endmodule

// File: rtl/rotimm_search.sv
module rotimm_search
  import rotimm_pkg::*;
(
  input  word_t             value_i,
  output logic [ROT_N-1:0]  hit_o,
  output logic [ROT_N-1:0]  first_hit_o,
  output logic              ok_o,
  output field_t            field_o
);
  word_t             cand [ROT_N];
  logic [ROT_N-1:0]  hit;
  logic [ROT_N-1:0]  first;
  rot_t              rot_sel;

  // One candidate per rotation: undo the rotation and see if it fits the payload.
  for (genvar r = 0; r < ROT_N; r++) begin : g_cand
    assign cand[r] = rot_left(value_i, r * ROT_STEP);
    assign hit[r]  = (cand[r][WORD_W-1:IMM_W] == '0);
  end

  // Lowest set bit wins: smallest rotation count.
  assign first = hit & ~(hit - ROT_N'(1));

  always_comb begin
    rot_sel = '0;
    for (int r = ROT_N - 1; r >= 0; r--) begin
      if (first[r]) rot_sel = rot_t'(r);
    end
  end

  assign hit_o       = hit;
  assign first_hit_o = first;
  assign ok_o        = |hit;
  assign field_o     = ok_o ? {rot_sel, cand[rot_sel][IMM_W-1:0]} : '0;
endmodule

// File: rtl/rotimm_codec.sv
module rotimm_codec
  import rotimm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_in_valid,
  input  logic [FIELD_W-1:0]  dec_field,
  input  logic                dec_carry_in,
  output logic                dec_out_valid,
  output logic [WORD_W-1:0]   dec_value,
  output logic                dec_carry_out,
  input  logic                enc_in_valid,
  input  logic [WORD_W-1:0]   enc_value,
  output logic                enc_out_valid,
  output logic                enc_ok,
  output logic [FIELD_W-1:0]  enc_field
);
  // Combinational stage outputs, named for the checks below.
  word_t             exp_value;
  logic              exp_carry;
  logic              exp_rot_zero;
  logic [ROT_N-1:0]  srch_hit;
  logic [ROT_N-1:0]  srch_first;
  logic              srch_ok;
  field_t            srch_field;
  logic              dec_rot_zero_q;

  rotimm_expand u_expand (
    .field_i    (dec_field),
    .carry_i    (dec_carry_in),
    .value_o    (exp_value),
    .carry_o    (exp_carry),
    .rot_zero_o (exp_rot_zero)
  );

  rotimm_search u_search (
    .value_i     (enc_value),
    .hit_o       (srch_hit),
    .first_hit_o (srch_first),
    .ok_o        (srch_ok),
    .field_o     (srch_field)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_out_valid  <= 1'b0;
      dec_value      <= '0;
      dec_carry_out  <= 1'b0;
      dec_rot_zero_q <= 1'b0;
    end else begin
      dec_out_valid <= dec_in_valid;
      if (dec_in_valid) begin
        dec_value      <= exp_value;
        dec_carry_out  <= exp_carry;
        dec_rot_zero_q <= exp_rot_zero;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_out_valid <= 1'b0;
      enc_ok        <= 1'b0;
      enc_field     <= '0;
    end else begin
      enc_out_valid <= enc_in_valid;
      if (enc_in_valid) begin
        enc_ok    <= srch_ok;
        enc_field <= srch_field;
      end
    end
  end

  // Carry source for a rotated field is the top bit of the constant.
  assert_carry_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_rot_zero_q |-> dec_carry_out == dec_value[WORD_W-1]);

  // Unrotated field passes the incoming carry through.
  assert_carry_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && dec_rot_zero_q |-> dec_carry_out == $past(dec_carry_in));

  // An accepted encoding decodes back to the requested constant.
  assert_roundtrip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && enc_ok |-> field_to_word(enc_field) == $past(enc_value));

  // A minimal field with nonzero rotation cannot have two low zero bits,
  // otherwise one step less of rotation would also fit.
  assert_minimal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && enc_ok && field_rot(enc_field) != '0 |-> enc_field[1:0] != 2'b00);

  // The priority pick selects at most one rotation, and only a fitting one.
  assert_single_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(srch_first) && ((srch_first & ~srch_hit) == '0));

  // Rejected constants report an all-zero field.
  assert_reject_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_ok |-> enc_field == '0);

  // Results hold between requests.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enc_in_valid) |-> $stable(enc_field) && $stable(enc_ok));
endmodule

// File: tb/tb_rotimm_codec.sv
`timescale 1ns/1ps
module tb_rotimm_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_in_valid = 1'b0;
  logic [11:0] dec_field = '0;
  logic        dec_carry_in = 1'b0;
  logic        dec_out_valid;
  logic [31:0] dec_value;
  logic        dec_carry_out;
  logic        enc_in_valid = 1'b0;
  logic [31:0] enc_value = '0;
  logic        enc_out_valid;
  logic        enc_ok;
  logic [11:0] enc_field;

  int n_checks = 0;
  int n_fails  = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  rotimm_codec dut (
    .clk(clk), .rst_n(rst_n),
    .dec_in_valid(dec_in_valid), .dec_field(dec_field), .dec_carry_in(dec_carry_in),
    .dec_out_valid(dec_out_valid), .dec_value(dec_value), .dec_carry_out(dec_carry_out),
    .enc_in_valid(enc_in_valid), .enc_value(enc_value),
    .enc_out_valid(enc_out_valid), .enc_ok(enc_ok), .enc_field(enc_field)
  );

  // Decode vectors: {field, carry_in, value, carry_out}
  localparam logic [45:0] DEC_VEC [10] = '{
    {12'h002, 1'b0, 32'h0000_0002, 1'b0},
    {12'h0FF, 1'b1, 32'h0000_00FF, 1'b1},
    {12'h0FF, 1'b0, 32'h0000_00FF, 1'b0},
    {12'h808, 1'b0, 32'h0008_0000, 1'b0},
    {12'h1FF, 1'b0, 32'hC000_003F, 1'b1},
    {12'h1FC, 1'b1, 32'h0000_003F, 1'b0},
    {12'h4FF, 1'b0, 32'hFF00_0000, 1'b1},
    {12'h2FF, 1'b0, 32'hF000_000F, 1'b1},
    {12'h702, 1'b1, 32'h0008_0000, 1'b0},
    {12'hF01, 1'b0, 32'h0000_0004, 1'b0}
  };
  // Encode vectors: {value, ok, field}
  localparam logic [44:0] ENC_VEC [8] = '{
    {32'h0008_0000, 1'b1, 12'h702},
    {32'h0000_0000, 1'b1, 12'h000},
    {32'h0000_003F, 1'b1, 12'h03F},
    {32'hC000_003F, 1'b1, 12'h1FF},
    {32'hFF00_0000, 1'b1, 12'h4FF},
    {32'hF000_000F, 1'b1, 12'h2FF},
    {32'h0000_0101, 1'b0, 12'h000},
    {32'hFFFF_FFFF, 1'b0, 12'h000}
  };

  function automatic logic [31:0] m_dec(logic [11:0] f);
    logic [63:0] dbl;
    int sh;
    sh  = 2 * f[11:8];
    dbl = {24'h0, f[7:0], 24'h0, f[7:0]};
    return dbl[31:0] >> sh | (dbl[63:32] << (32 - sh)) & ((sh == 0) ? 32'h0 : 32'hFFFF_FFFF);
  endfunction

  function automatic logic [11:0] m_enc(logic [31:0] v, output bit ok);
    ok = 0;
    for (int r = 0; r < 16; r++) begin
      for (int imm = 0; imm < 256; imm += 1) begin
        if (!ok && m_dec({r[3:0], imm[7:0]}) == v) begin
          ok = 1;
          return {r[3:0], imm[7:0]};
        end
        if (ok) break;
      end
    end
    return 12'h000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    end
    $finish;
  endtask

  // Drive one request on each side, sample after the next rising edge.
  task automatic issue(logic [11:0] f, logic ci, logic [31:0] v);
    @(negedge clk);
    dec_in_valid = 1'b1; dec_field = f; dec_carry_in = ci;
    enc_in_valid = 1'b1; enc_value = v;
    @(negedge clk);
    dec_in_valid = 1'b0; enc_in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    bit eok;
    logic [11:0] ef;
    logic [31:0] dv;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 dec_out_valid", 32'(dec_out_valid), 0);
    check("R8 dec_value", dec_value, 0);
    check("R8 dec_carry_out", 32'(dec_carry_out), 0);
    check("R8 enc_out_valid", 32'(enc_out_valid), 0);
    check("R8 enc_ok", 32'(enc_ok), 0);
    check("R8 enc_field", 32'(enc_field), 0);
    rst_n = 1'b1;

    // R1 R2 R3: decode table
    for (int i = 0; i < 10; i++) begin
      issue(DEC_VEC[i][45:34], DEC_VEC[i][33], 32'h0);
      check("R1 R2 decode value", dec_value, DEC_VEC[i][32:1]);
      check("R3 carry", 32'(dec_carry_out), 32'(DEC_VEC[i][0]));
      check("R7 dec strobe", 32'(dec_out_valid), 1);
    end
    // R4 R5 R6: encode table
    for (int i = 0; i < 8; i++) begin
      issue(12'h000, 1'b0, ENC_VEC[i][44:13]);
      check("R4 R6 enc_ok", 32'(enc_ok), 32'(ENC_VEC[i][12]));
      check("R5 R6 enc_field", 32'(enc_field), 32'(ENC_VEC[i][11:0]));
      check("R7 enc strobe", 32'(enc_out_valid), 1);
    end

    // R7: hold with no request, then strobes low
    issue(12'h4FF, 1'b0, 32'hFF00_0000);
    @(negedge clk);
    dec_field = 12'h123; enc_value = 32'h0000_0101;
    @(negedge clk);
    check("R7 dec strobe low", 32'(dec_out_valid), 0);
    check("R7 enc strobe low", 32'(enc_out_valid), 0);
    check("R7 dec hold", dec_value, 32'hFF00_0000);
    check("R7 enc hold", 32'(enc_field), 32'h4FF);

    // R4 R5: exhaustive field sweep, decode then minimal re-encode
    for (int f = 0; f < 4096; f++) begin
      dv = m_dec(f[11:0]);
      ef = m_enc(dv, eok);
      issue(f[11:0], 1'b0, dv);
      check("R1 sweep decode", dec_value, dv);
      check("R4 sweep enc_ok", 32'(enc_ok), 1);
      check("R5 sweep minimal field", 32'(enc_field), 32'(ef));
    end

    // R8: reset mid-run clears outputs
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 reassert dec_value", dec_value, 0);
    check("R8 reassert enc_field", 32'(enc_field), 0);
    report();
  end
endmodule